// File: doc/BRIEF.md
# Sigma-Delta Converter Bring-Up and Calibration Sequencer

This block is the host-side controller that brings an external sigma-delta converter out of reset and calibrates it. A `start` pulse makes it send a serial-interface reset pattern and wait a settling time. It then reads the identification register and programs the mode, configuration and (optionally) excitation-current registers. Last, it runs a zero-scale and full-scale calibration on each of three input channels. Every calibration step is followed by status polling until the converter reports ready. A bounded poll count turns a converter that never reports ready into an error.

The block talks to the converter only through a byte-level transfer port. It raises `xfer_start` for one cycle with a byte on `xfer_tx`. The bit-level serial engine returns the received byte on `xfer_rx` with a one-cycle `xfer_done`. `spi_sel` stays high across all bytes of one register access. After a successful bring-up, `recal_req` asks the block to apply the current gain, polarity and buffer inputs. The block writes the configuration register and recalibrates only when the resulting configuration word differs from the one it last wrote.

Top module: `adc_bringup_seq`

## Requirements
- R1: After `start`, the first transaction is four bytes, each 0xFF.
- R2: After the reset pattern, `spi_sel` stays low for at least `SETTLE_CYC` cycles before the next transaction.
- R3: The identification read is command byte 0x60 followed by one dummy byte 0x00. Only the low 4 bits of the second received byte are compared with `ID_EXP`; bits 7:4 are ignored. On a mismatch the block raises `error`, issues no further transaction and does not pulse `done`.
- R4: The mode write is command 0x08 followed by a 16-bit word, MSB first. The word has operation code 2 in bits 15:13, `cfg_clk_src` in bits 7:6, update rate 1 in bits 3:0 and zeros elsewhere.
- R5: The configuration write is command 0x10 followed by a 16-bit word, MSB first. The word has `cfg_unipolar` in bit 12, `cfg_gain` in bits 10:8, `cfg_buffered` in bit 4, the channel number in bits 3:0 (0 here) and zeros elsewhere.
- R6: When `cfg_exc_en` is 1, the next transaction is command 0x28 followed by one byte with `cfg_exc_dir` in bits 3:2 and `cfg_exc_cur` in bits 1:0. When `cfg_exc_en` is 0, no such transaction occurs.
- R7: Calibration runs on channels 0, 1 and 2 in turn. Each channel gets a zero-scale step (operation code 4), then a full-scale step (operation code 5). Each step is a configuration write with that channel in bits 3:0, then a mode write with the step's code in bits 15:13 and the other mode bits as in R4.
- R8: After each calibration mode write, the block issues status reads (command 0x40 followed by dummy 0x00) until the second received byte has bit 7 set. If `POLL_MAX` reads all show bit 7 clear, it raises `error` after the last one.
- R9: `done` is high for exactly one cycle when a sequence completes. `busy` is high while a sequence runs and low whenever `done` is high.
- R10: `error` stays high until the next `start`, which clears it on the following cycle. `recal_req` does not clear it.
- R11: In the ready state, `recal_req` has two outcomes. If the configuration word from the current inputs (channel 0) differs from the stored word, the block writes it and then reruns the full R7/R8 calibration. Otherwise it pulses `done` with no transfer.
- R12: Each `xfer_start` is a one-cycle pulse, issued only with `spi_sel` high and never while an earlier byte is still awaiting `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin full bring-up (accepted when not busy) |
| recal_req | input | 1 | Configuration may have changed; recalibrate if it did |
| cfg_gain | input | 3 | Gain code for the configuration word |
| cfg_unipolar | input | 1 | Unipolar coding select |
| cfg_buffered | input | 1 | Input buffer enable |
| cfg_clk_src | input | 2 | Converter clock source code |
| cfg_exc_en | input | 1 | Program the excitation register |
| cfg_exc_cur | input | 2 | Excitation current code |
| cfg_exc_dir | input | 2 | Excitation routing code |
| spi_sel | output | 1 | Chip select, high for the whole register access |
| xfer_start | output | 1 | One-cycle request to shift one byte |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_rx | input | 8 | Byte shifted in, valid with `xfer_done` |
| xfer_done | input | 1 | Byte transfer complete |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Sticky failure flag |

## Verification
The bench's serial model records every byte at its `xfer_start` and closes a transaction when `spi_sel` falls. Whole register accesses are therefore compared regardless of how many cycles each byte takes. `done` and `error` are waited for with a bounded loop. A few idle cycles then pass before the log is read, so the last transaction is closed. The settling gap is measured in cycles between the fall of `spi_sel` after the reset pattern and its next rise. The clearing of `error` is sampled on the first falling edge after the rising edge that takes `start`. The no-traffic outcome of R11 is judged after 30 idle cycles, which is longer than any single transfer takes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_RST,
        ST_SETTLE,
        ST_ID,
        ST_MODE,
        ST_CONF,
        ST_IO,
        ST_RC_CONF,
        ST_CAL_CONF,
        ST_CAL_MODE,
        ST_POLL,
        ST_READY,
        ST_FAIL
    } seq_state_e;

    localparam logic [2:0] A_STAT = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_CONF = 3'd2;
    localparam logic [2:0] A_ID   = 3'd4;
    localparam logic [2:0] A_IO   = 3'd5;

    localparam logic [2:0] OP_IDLE  = 3'd2;
    localparam logic [2:0] OP_CAL_Z = 3'd4;
    localparam logic [2:0] OP_CAL_F = 3'd5;

    localparam int RDY_BIT = 7;

    // command byte: bit6 = read, bits 5:3 = register address
    function automatic logic [7:0] cmd_byte(input logic rd, input logic [2:0] addr);
        return {1'b0, rd, addr, 3'b000};
    endfunction

    function automatic logic [15:0] mode_word(input logic [2:0] op, input logic [1:0] clk_src);
        return {op, 5'b0, clk_src, 2'b0, 4'h1};
    endfunction

    function automatic logic [15:0] conf_word(input logic uni, input logic [2:0] gain,
                                              input logic buf_en, input logic [3:0] chan);
        return {3'b0, uni, 1'b0, gain, 3'b0, buf_en, chan};
    endfunction

endpackage

// File: rtl/adc_seq_counter.sv
module adc_seq_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && cnt_q != LAST)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == LAST);
endmodule

// File: rtl/adc_byte_txn.sv
module adc_byte_txn #(
    parameter int MAX_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go,
    input  logic [2:0]               len,
    input  logic [8*MAX_BYTES-1:0]   data,
    output logic                     sel,
    output logic                     xfer_start,
    output logic [7:0]               xfer_tx,
    input  logic [7:0]               xfer_rx,
    input  logic                     xfer_done,
    output logic                     txn_done,
    output logic [7:0]               rx_last
);
    localparam int DW = 8 * MAX_BYTES;

    typedef struct packed {
        logic          active;
        logic          waiting;
        logic [2:0]    left;
        logic [DW-1:0] sh;
        logic          start;
        logic [7:0]    tx;
        logic [7:0]    rx;
        logic          done;
    } txn_s;

    txn_s q, d;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.done  = 1'b0;
        if (!q.active) begin
            if (go) begin
                d.active  = 1'b1;
                d.waiting = 1'b0;
                d.left    = len;
                d.sh      = data;
            end
        end else if (!q.waiting) begin
            d.start   = 1'b1;
            d.tx      = q.sh[DW-1 -: 8];
            d.waiting = 1'b1;
        end else if (xfer_done) begin
            d.waiting = 1'b0;
            d.rx      = xfer_rx;
            d.sh      = q.sh << 8;
            d.left    = q.left - 3'd1;
            if (q.left == 3'd1) begin
                d.active = 1'b0;
                d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sel        = q.active;
    assign xfer_start = q.start;
    assign xfer_tx    = q.tx;
    assign txn_done   = q.done;
    assign rx_last    = q.rx;
endmodule

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq
    import adc_seq_pkg::*;
#(
    parameter logic [3:0] ID_EXP     = 4'hB,
    parameter int         SETTLE_CYC = 50000,
    parameter int         POLL_MAX   = 1000,
    parameter int         N_CAL_CH   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       recal_req,
    input  logic [2:0] cfg_gain,
    input  logic       cfg_unipolar,
    input  logic       cfg_buffered,
    input  logic [1:0] cfg_clk_src,
    input  logic       cfg_exc_en,
    input  logic [1:0] cfg_exc_cur,
    input  logic [1:0] cfg_exc_dir,
    output logic       spi_sel,
    output logic       xfer_start,
    output logic [7:0] xfer_tx,
    input  logic [7:0] xfer_rx,
    input  logic       xfer_done,
    output logic       busy,
    output logic       done,
    output logic       error
);
    localparam int              CH_W    = (N_CAL_CH > 1) ? $clog2(N_CAL_CH) : 1;
    localparam logic [CH_W-1:0] CH_LAST = CH_W'(N_CAL_CH - 1);

    localparam logic [7:0] C_WR_MODE = cmd_byte(1'b0, A_MODE);
    localparam logic [7:0] C_WR_CONF = cmd_byte(1'b0, A_CONF);
    localparam logic [7:0] C_WR_IO   = cmd_byte(1'b0, A_IO);
    localparam logic [7:0] C_RD_ID   = cmd_byte(1'b1, A_ID);
    localparam logic [7:0] C_RD_STAT = cmd_byte(1'b1, A_STAT);

    typedef struct packed {
        seq_state_e      st;
        logic            issued;
        logic [CH_W-1:0] ch;
        logic            full;
        logic [15:0]     conf;
        logic [1:0]      clk_src;
        logic            go;
        logic [2:0]      len;
        logic [31:0]     data;
        logic            done;
        logic            err;
    } seq_s;

    seq_s q, d;

    logic       txn_done;
    logic [7:0] rx_byte;
    logic       settle_hit, poll_hit;
    logic       settle_clr, settle_inc, poll_clr, poll_inc;

    adc_byte_txn #(.MAX_BYTES(4)) txn_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (q.go),
        .len        (q.len),
        .data       (q.data),
        .sel        (spi_sel),
        .xfer_start (xfer_start),
        .xfer_tx    (xfer_tx),
        .xfer_rx    (xfer_rx),
        .xfer_done  (xfer_done),
        .txn_done   (txn_done),
        .rx_last    (rx_byte)
    );

    assign settle_clr = (q.st != ST_SETTLE);
    assign settle_inc = (q.st == ST_SETTLE);
    assign poll_clr   = (q.st == ST_CAL_CONF);
    assign poll_inc   = (q.st == ST_POLL) && txn_done && !rx_byte[RDY_BIT];

    adc_seq_counter #(.LIMIT(SETTLE_CYC)) settle_cnt_i (
        .clk (clk), .rst_n (rst_n), .clr (settle_clr), .inc (settle_inc), .hit (settle_hit)
    );

    adc_seq_counter #(.LIMIT(POLL_MAX)) poll_cnt_i (
        .clk (clk), .rst_n (rst_n), .clr (poll_clr), .inc (poll_inc), .hit (poll_hit)
    );

    logic [15:0] new_conf, cal_conf, cal_mode;

    always_comb begin
        new_conf = conf_word(cfg_unipolar, cfg_gain, cfg_buffered, 4'd0);
        cal_conf = {q.conf[15:4], 4'(q.ch)};
        cal_mode = mode_word(q.full ? OP_CAL_F : OP_CAL_Z, q.clk_src);

        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;

        case (q.st)
            ST_OFF, ST_READY, ST_FAIL: begin
                if (start) begin
                    d.err    = 1'b0;
                    d.issued = 1'b0;
                    d.st     = ST_RST;
                end else if (q.st == ST_READY && recal_req) begin
                    if (new_conf != q.conf) begin
                        d.conf   = new_conf;
                        d.issued = 1'b0;
                        d.st     = ST_RC_CONF;
                    end else begin
                        d.done = 1'b1;
                    end
                end
            end
            ST_RST: begin
                if (!q.issued) begin
                    d.go = 1'b1; d.len = 3'd4; d.data = 32'hFFFF_FFFF; d.issued = 1'b1;
                end else if (txn_done) begin
                    d.issued = 1'b0; d.st = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (settle_hit) d.st = ST_ID;
            end
            ST_ID: begin
                if (!q.issued) begin
                    d.go = 1'b1; d.len = 3'd2; d.data = {C_RD_ID, 24'h0}; d.issued = 1'b1;
                end else if (txn_done) begin
                    d.issued = 1'b0;
                    if (rx_byte[3:0] != ID_EXP) begin
                        d.err = 1'b1; d.st = ST_FAIL;
                    end else begin
                        d.st = ST_MODE;
                    end
                end
            end
            ST_MODE: begin
                if (!q.issued) begin
                    d.clk_src = cfg_clk_src;
                    d.go = 1'b1; d.len = 3'd3; d.issued = 1'b1;
                    d.data = {C_WR_MODE, mode_word(OP_IDLE, cfg_clk_src), 8'h0};
                end else if (txn_done) begin
                    d.issued = 1'b0; d.st = ST_CONF;
                end
            end
            ST_CONF: begin
                if (!q.issued) begin
                    d.conf = new_conf;
                    d.go = 1'b1; d.len = 3'd3; d.issued = 1'b1;
                    d.data = {C_WR_CONF, new_conf, 8'h0};
                end else if (txn_done) begin
                    d.issued = 1'b0;
                    d.ch     = '0;
                    d.full   = 1'b0;
                    d.st     = cfg_exc_en ? ST_IO : ST_CAL_CONF;
                end
            end
            ST_IO: begin
                if (!q.issued) begin
                    d.go = 1'b1; d.len = 3'd2; d.issued = 1'b1;
                    d.data = {C_WR_IO, 4'h0, cfg_exc_dir, cfg_exc_cur, 16'h0};
                end else if (txn_done) begin
                    d.issued = 1'b0; d.st = ST_CAL_CONF;
                end
            end
            ST_RC_CONF: begin
                if (!q.issued) begin
                    d.go = 1'b1; d.len = 3'd3; d.issued = 1'b1;
                    d.data = {C_WR_CONF, q.conf, 8'h0};
                end else if (txn_done) begin
                    d.issued = 1'b0; d.ch = '0; d.full = 1'b0; d.st = ST_CAL_CONF;
                end
            end
            ST_CAL_CONF: begin
                if (!q.issued) begin
                    d.go = 1'b1; d.len = 3'd3; d.issued = 1'b1;
                    d.data = {C_WR_CONF, cal_conf, 8'h0};
                end else if (txn_done) begin
                    d.issued = 1'b0; d.st = ST_CAL_MODE;
                end
            end
            ST_CAL_MODE: begin
                if (!q.issued) begin
                    d.go = 1'b1; d.len = 3'd3; d.issued = 1'b1;
                    d.data = {C_WR_MODE, cal_mode, 8'h0};
                end else if (txn_done) begin
                    d.issued = 1'b0; d.st = ST_POLL;
                end
            end
            ST_POLL: begin
                if (!q.issued) begin
                    d.go = 1'b1; d.len = 3'd2; d.issued = 1'b1;
                    d.data = {C_RD_STAT, 24'h0};
                end else if (txn_done) begin
                    d.issued = 1'b0;
                    if (rx_byte[RDY_BIT]) begin
                        if (!q.full) begin
                            d.full = 1'b1; d.st = ST_CAL_CONF;
                        end else if (q.ch == CH_LAST) begin
                            d.done = 1'b1; d.st = ST_READY;
                        end else begin
                            d.full = 1'b0; d.ch = q.ch + 1'b1; d.st = ST_CAL_CONF;
                        end
                    end else if (poll_hit) begin
                        d.err = 1'b1; d.st = ST_FAIL;
                    end
                end
            end
            default: d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_OFF;
        end else begin
            q <= d;
        end
    end

    assign busy  = !(q.st == ST_OFF || q.st == ST_READY || q.st == ST_FAIL);
    assign done  = q.done;
    assign error = q.err;
endmodule

// File: rtl/adc_bringup_chk.sv
module adc_bringup_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic spi_sel,
    input logic xfer_start,
    input logic xfer_done,
    input logic busy,
    input logic done,
    input logic error
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (xfer_start) pend_q <= 1'b1;
        else if (xfer_done)  pend_q <= 1'b0;
    end

    a_r12_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    a_r12_start_selected: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> spi_sel);

    a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !pend_q);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !error));

    a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);
endmodule

bind adc_bringup_seq adc_bringup_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .spi_sel    (spi_sel),
    .xfer_start (xfer_start),
    .xfer_done  (xfer_done),
    .busy       (busy),
    .done       (done),
    .error      (error)
);

// File: tb/adc_bringup_seq_tb_top.sv
module adc_bringup_seq_tb_top;
    localparam int SETTLE = 40;
    localparam int PMAX   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, recal_req = 1'b0;
    logic [2:0] cfg_gain = '0;
    logic       cfg_unipolar = 1'b0, cfg_buffered = 1'b0, cfg_exc_en = 1'b0;
    logic [1:0] cfg_clk_src = '0, cfg_exc_cur = '0, cfg_exc_dir = '0;
    logic       spi_sel, xfer_start, busy, done, error;
    logic [7:0] xfer_tx;
    logic [7:0] xfer_rx = '0;
    logic       xfer_done = 1'b0;

    always #5 clk = ~clk;

    adc_bringup_seq #(.ID_EXP(4'hB), .SETTLE_CYC(SETTLE), .POLL_MAX(PMAX), .N_CAL_CH(3)) dut_i (
        .clk, .rst_n, .start, .recal_req, .cfg_gain, .cfg_unipolar, .cfg_buffered,
        .cfg_clk_src, .cfg_exc_en, .cfg_exc_cur, .cfg_exc_dir, .spi_sel, .xfer_start,
        .xfer_tx, .xfer_rx, .xfer_done, .busy, .done, .error
    );

    int checks = 0, errs = 0;

    // converter model and transaction log
    logic [7:0]  id_resp = 8'hFB;
    int          rdy_after = 1;
    logic        clr_log = 1'b0;
    int          stat_reads = 0, log_n = 0, cur_n = 0, dly = 0, done_cnt = 0, gap = -1;
    logic [31:0] log_dat [0:127];
    int          log_len [0:127];
    logic [31:0] cur_dat = '0;
    logic [7:0]  rsp = '0;
    logic        sel_prev = 1'b0;
    longint      cyc = 0, fall_cyc = 0;

    always @(negedge clk) begin
        cyc++;
        if (clr_log) begin
            log_n = 0; done_cnt = 0; stat_reads = 0; gap = -1;
        end
        xfer_done = 1'b0;
        if (dly > 0) begin
            dly--;
            if (dly == 0) begin xfer_done = 1'b1; xfer_rx = rsp; end
        end
        if (spi_sel && xfer_start) begin
            cur_dat = cur_dat | ({24'h0, xfer_tx} << (24 - 8 * cur_n));
            rsp = 8'h00;
            if (cur_n == 1 && cur_dat[31:24] == 8'h60) rsp = id_resp;
            if (cur_n == 1 && cur_dat[31:24] == 8'h40) begin
                stat_reads++;
                rsp = (stat_reads >= rdy_after) ? 8'h80 : 8'h00;
            end
            cur_n++;
            dly = 2;
        end
        if (spi_sel && !sel_prev && log_n == 1) gap = int'(cyc - fall_cyc);
        if (!spi_sel && sel_prev) begin
            log_dat[log_n] = cur_dat;
            log_len[log_n] = cur_n;
            if (cur_dat[31:24] == 8'h08) stat_reads = 0;
            if (log_n == 0) fall_cyc = cyc;
            log_n++;
            cur_dat = '0;
            cur_n = 0;
        end
        sel_prev = spi_sel;
        if (done) done_cnt++;
    end

    // expected transactions
    logic [31:0] exp_dat [0:127];
    int          exp_len [0:127];
    string       exp_req [0:127];
    int          exp_n = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic add_exp(input int len, input logic [31:0] dat, input string req);
        exp_len[exp_n] = len; exp_dat[exp_n] = dat; exp_req[exp_n] = req; exp_n++;
    endtask

    function automatic logic [15:0] tb_conf(input logic [2:0] g, input logic u, input logic b,
                                            input int ch);
        logic [15:0] w;
        w = 16'h0;
        w[12] = u; w[10:8] = g; w[4] = b; w[3:0] = 4'(ch);
        return w;
    endfunction

    function automatic logic [15:0] tb_mode(input int op, input logic [1:0] cs);
        logic [15:0] w;
        w = 16'h0001;
        w[15:13] = 3'(op); w[7:6] = cs;
        return w;
    endfunction

    task automatic add_cal(input logic [2:0] g, input logic u, input logic b,
                           input logic [1:0] cs, input int rdy);
        for (int ch = 0; ch < 3; ch++) begin
            for (int op = 4; op <= 5; op++) begin
                add_exp(3, {8'h10, tb_conf(g, u, b, ch), 8'h00}, "R7");
                add_exp(3, {8'h08, tb_mode(op, cs), 8'h00}, "R7");
                for (int k = 0; k < rdy; k++) add_exp(2, 32'h4000_0000, "R8");
            end
        end
    endtask

    task automatic compare_log();
        chk(log_n == exp_n, "R7", "transaction count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk(log_dat[i] == exp_dat[i] && log_len[i] == exp_len[i], exp_req[i],
                $sformatf("transaction %0d (len %0d/%0d)", i, log_len[i], exp_len[i]),
                log_dat[i], exp_dat[i]);
        end
    endtask

    task automatic clear_log();
        clr_log = 1'b1;
        repeat (2) @(negedge clk);
        clr_log = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(input bit is_start);
        if (is_start) start = 1'b1; else recal_req = 1'b1;
        @(negedge clk);
        start = 1'b0; recal_req = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20000; i++) begin
            if (done_cnt > 0 || error) break;
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    // stimulus vectors: gain, unipolar, buffered, clk_src, exc_en, exc_cur, exc_dir, ready-after
    localparam int NV = 4;
    localparam logic [14:0] VEC [NV] = '{
        {3'd0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 2'd0, 3'd1},
        {3'd7, 1'b1, 1'b0, 2'd2, 1'b1, 2'd3, 2'd1, 3'd3},
        {3'd3, 1'b0, 1'b0, 2'd1, 1'b1, 2'd1, 2'd2, 3'd2},
        {3'd5, 1'b1, 1'b1, 2'd3, 1'b0, 2'd2, 2'd3, 3'd4}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin : main
        int sreads;
        repeat (4) @(negedge clk);
        chk(!spi_sel && !xfer_start, "R12", "reset select/start", {spi_sel, xfer_start}, 0);
        chk(!busy && !done && !error, "R9", "reset busy/done/error", {busy, done, error}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            {cfg_gain, cfg_unipolar, cfg_buffered, cfg_clk_src, cfg_exc_en,
             cfg_exc_cur, cfg_exc_dir} = VEC[v][14:3];
            rdy_after = int'(VEC[v][2:0]);
            exp_n = 0;
            add_exp(4, 32'hFFFF_FFFF, "R1");
            add_exp(2, 32'h6000_0000, "R3");
            add_exp(3, {8'h08, tb_mode(2, cfg_clk_src), 8'h00}, "R4");
            add_exp(3, {8'h10, tb_conf(cfg_gain, cfg_unipolar, cfg_buffered, 0), 8'h00}, "R5");
            if (cfg_exc_en) add_exp(2, {8'h28, 4'h0, cfg_exc_dir, cfg_exc_cur, 16'h0}, "R6");
            add_cal(cfg_gain, cfg_unipolar, cfg_buffered, cfg_clk_src, rdy_after);
            clear_log();
            pulse(1'b1);
            chk(busy, "R9", "busy during sequence", busy, 1);
            wait_end();
            chk(!error, "R3", "no error with matching low ID nibble", error, 0);
            chk(done_cnt == 1, "R9", "done pulse cycles", done_cnt, 1);
            chk(gap >= SETTLE, "R2", "settle gap cycles", gap, SETTLE);
            compare_log();
        end

        // R11: unchanged configuration -> done with no traffic
        clear_log();
        pulse(1'b0);
        repeat (30) @(negedge clk);
        chk(log_n == 0, "R11", "transfers on unchanged recal", log_n, 0);
        chk(done_cnt == 1, "R11", "done on unchanged recal", done_cnt, 1);

        // R11: gain changed -> configuration write and full recalibration
        cfg_gain = 3'd1;
        rdy_after = 2;
        exp_n = 0;
        add_exp(3, {8'h10, tb_conf(3'd1, cfg_unipolar, cfg_buffered, 0), 8'h00}, "R11");
        add_cal(3'd1, cfg_unipolar, cfg_buffered, cfg_clk_src, 2);
        clear_log();
        pulse(1'b0);
        wait_end();
        chk(done_cnt == 1, "R11", "done after recalibration", done_cnt, 1);
        compare_log();

        // R3: ID mismatch
        id_resp = 8'hBA;
        clear_log();
        pulse(1'b1);
        wait_end();
        chk(error, "R3", "error on ID mismatch", error, 1);
        chk(log_n == 2, "R3", "transfers after ID mismatch", log_n, 2);
        chk(done_cnt == 0, "R3", "no done on ID mismatch", done_cnt, 0);

        // R10: error sticky, recal does not clear it
        repeat (20) @(negedge clk);
        chk(error, "R10", "error held", error, 1);
        pulse(1'b0);
        repeat (20) @(negedge clk);
        chk(error && log_n == 2, "R10", "recal ignored in error", {error, 8'(log_n)}, {1'b1, 8'd2});

        // R8: converter never ready -> timeout error after POLL_MAX reads
        id_resp = 8'hFB;
        rdy_after = 1000;
        clear_log();
        pulse(1'b1);
        chk(!error, "R10", "start clears error", error, 0);
        wait_end();
        chk(error, "R8", "error on poll timeout", error, 1);
        sreads = 0;
        for (int i = 0; i < log_n; i++) if (log_dat[i] == 32'h4000_0000) sreads++;
        chk(sreads == PMAX, "R8", "status reads before timeout", sreads, PMAX);
        chk(done_cnt == 0, "R8", "no done on timeout", done_cnt, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule